// File: doc/BRIEF.md
# Framed Synchronous Serial Port Controller

This block is the device side of a synchronous serial link to a DSP host. Each sample period it moves one 16-bit word from the device to the host and one 16-bit word from the host to the device. Every sample period also contains one control frame. In that frame the host sends a 16-bit command that reads or writes one 8-bit register, and the device replies in the same slot. The sample period is `FRAME_BITS` serial clock cycles, where `FRAME_BITS` is a power of two and at least 128.

In master mode the block sets the framing itself, with one internal cycle per serial bit. It drives the frame sync and a clock-enable output. The enable either stays high or is gated to 32 cycles after each frame sync. In slave mode the host supplies the bit strobe and the frame sync, and bit positions advance only on host strobes. In either mode a delayed frame sync can be forwarded to a further device, so that devices chained on one host each take the next 16-bit slot.

The frame sync comes in two forms. In the late form it is high during the first bit of a frame. In the early form it is high during the bit position just before the frame. The control frame starts either halfway through the sample period or a quarter of the way through it.

Top module: `framed_serial_port`

## Requirements
- R1: In master mode the data frame sync `fsOut` is a one-cycle pulse every `FRAME_BITS` cycles. With `fsEarly`=0 it is high at bit position 0. With `fsEarly`=1 it is high at position `FRAME_BITS`-1. After reset the position counter starts at 0.
- R2: A second `fsOut` pulse marks the control frame, which starts at position P. P is `FRAME_BITS`/2 when `ctrlQuarter`=0 and `FRAME_BITS`/4 when it is 1. The pulse is at P in the late form and at P-1 in the early form.
- R3: With `sckContinuous`=1, `sclkGate` is always high in master mode. With 0, it is high only during the 32 cycles that begin with each `fsOut` pulse.
- R4: With `fsdEnable`=1, `fsdOut` pulses exactly 16 bit positions after each frame sync, for data and control frames alike. With `fsdEnable`=0 it stays low.
- R5: Bit positions 0 to 15 form the data slot, sent and received MSB first. `sdOut` sends the `adcWord` value sampled at position `FRAME_BITS`-1. The 16 `sdIn` bits appear on `dacWord`, with `dacValid` high for one cycle, in the cycle after the last bit.
- R6: The control word on `sdIn` occupies positions P to P+15. Bit 15 is the read flag (1 = read), bits 14:8 are the address and bits 7:0 are the write data. On a read, `regRead` pulses with `regAddr` valid in the cycle that carries bit 8. `sdOut` then sends eight zeros followed by `regRData` sampled in that cycle.
- R7: A write command pulses `regWrite` for one cycle after its last bit, with `regAddr` and `regWData` set from the command. Its reply is all zeros. A read command never pulses `regWrite`.
- R8: Outside the data and control slots `sdOut` is 0.
- R9: In slave mode `fsOut` and `sclkGate` stay low and positions advance only on cycles with `sclkIn` high. An `fsIn` pulse on such a cycle sets that bit position to 0 in the late form, or to `FRAME_BITS`-1 in the early form. Slots, replies and `fsdOut` follow the same rules in bit positions.
- R10: During reset and in the first data slot after it, `sdOut` is 0. In reset `dacValid`, `regRead` and `regWrite` are low and `dacWord` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one serial bit per cycle in master mode |
| rstN | input | 1 | Asynchronous active-low reset |
| slaveMode | input | 1 | 1 = framing from `sclkIn`/`fsIn` |
| fsEarly | input | 1 | 1 = early frame sync form, 0 = late |
| sckContinuous | input | 1 | 1 = serial clock enable never gated |
| ctrlQuarter | input | 1 | 1 = control frame at quarter period, 0 = half |
| fsdEnable | input | 1 | Enables the delayed frame sync output |
| sclkIn | input | 1 | Slave bit strobe from the host |
| fsIn | input | 1 | Slave frame sync from the host |
| sdIn | input | 1 | Serial data from the host |
| adcWord | input | 16 | Word sent to the host in the data slot |
| regRData | input | 8 | Register read data for the addressed register |
| sclkGate | output | 1 | Master serial clock enable |
| fsOut | output | 1 | Master frame sync |
| fsdOut | output | 1 | Delayed frame sync for the next device |
| sdOut | output | 1 | Serial data to the host |
| dacWord | output | 16 | Last data word received from the host |
| dacValid | output | 1 | One-cycle pulse when `dacWord` updates |
| regAddr | output | 7 | Register address of the current command |
| regWData | output | 8 | Register write data |
| regRead | output | 1 | One-cycle read request |
| regWrite | output | 1 | One-cycle write request |

## Verification
If the position counter drifts, every pulse and slot moves with it. The frame sync, delayed sync and clock gate would then show up at the wrong bit position within one sample period, and those three are compared against their expected positions every cycle. Errors in the shift registers or in their load points show at the end of the affected slot. A received word, a register request or the reply being sent comes out wrong within 16 bit positions of the slot start. A wrong load priority shows as a wrong reply for write commands or as stale data in the first frame after reset.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int REG_W       = 8;
  localparam int WORD_W      = 2 * REG_W;
  localparam int ADDR_W      = REG_W - 1;
  localparam int GATE_CYCLES = 32;
  localparam int FSD_DELAY   = WORD_W;

  typedef struct packed {
    logic tick;      // a bit position is consumed this cycle
    logic inSlot;    // position lies in the data or control slot
    logic loadAdc;   // last position of the period
    logic clearOut;  // position just before the control slot
    logic ctrlMid;   // control bit carrying the last address bit
    logic dataEnd;   // last bit of the data slot
    logic ctrlEnd;   // last bit of the control slot
  } fsp_strobe_t;
endpackage

// File: rtl/fsp_sequencer.sv
module fsp_sequencer
  import fsp_pkg::*;
#(
  parameter int FRAME_BITS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slaveMode,
  input  logic        fsEarly,
  input  logic        sckContinuous,
  input  logic        ctrlQuarter,
  input  logic        fsdEnable,
  input  logic        sclkIn,
  input  logic        fsIn,
  output logic        fsOut,
  output logic        fsdOut,
  output logic        sclkGate,
  output fsp_strobe_t strb
);
  localparam int CW        = $clog2(FRAME_BITS);
  localparam int HALF_POS  = FRAME_BITS / 2;
  localparam int QUART_POS = FRAME_BITS / 4;

  logic [CW-1:0] cnt, effCnt, ctrlPos, dataFs, ctrlFs, dData, dCtrl, relCtrl;
  logic          tick;

  always_comb begin
    tick    = slaveMode ? sclkIn : 1'b1;
    ctrlPos = ctrlQuarter ? CW'(QUART_POS) : CW'(HALF_POS);
    dataFs  = fsEarly ? CW'(FRAME_BITS - 1) : '0;
    ctrlFs  = fsEarly ? ctrlPos - CW'(1) : ctrlPos;
    effCnt  = (slaveMode && sclkIn && fsIn) ? dataFs : cnt;
    dData   = effCnt - dataFs;
    dCtrl   = effCnt - ctrlFs;
    relCtrl = effCnt - ctrlPos;

    fsOut    = !slaveMode && (dData == '0 || dCtrl == '0);
    fsdOut   = fsdEnable && tick &&
               (dData == CW'(FSD_DELAY) || dCtrl == CW'(FSD_DELAY));
    sclkGate = !slaveMode &&
               (sckContinuous || dData < CW'(GATE_CYCLES) || dCtrl < CW'(GATE_CYCLES));

    strb.tick     = tick;
    strb.inSlot   = (effCnt < CW'(WORD_W)) || (relCtrl < CW'(WORD_W));
    strb.loadAdc  = tick && (effCnt == CW'(FRAME_BITS - 1));
    strb.clearOut = tick && (relCtrl == '1);
    strb.ctrlMid  = tick && (relCtrl == CW'(REG_W - 1));
    strb.dataEnd  = tick && (effCnt == CW'(WORD_W - 1));
    strb.ctrlEnd  = tick && (relCtrl == CW'(WORD_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (tick) cnt <= effCnt + CW'(1);
  end
endmodule

// File: rtl/fsp_shifter.sv
module fsp_shifter
  import fsp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fsp_strobe_t       strb,
  input  logic              sdIn,
  input  logic [WORD_W-1:0] adcWord,
  input  logic [REG_W-1:0]  regRData,
  output logic              sdOut,
  output logic [WORD_W-1:0] dacWord,
  output logic              dacValid,
  output logic [ADDR_W-1:0] regAddr,
  output logic [REG_W-1:0]  regWData,
  output logic              regRead,
  output logic              regWrite
);
  logic [WORD_W-1:0] outSh, inSh;
  logic [ADDR_W-1:0] addrHold;
  logic              readHold;
  logic [ADDR_W-1:0] addrNow;
  logic              readNow;

  always_comb begin
    addrNow = {inSh[ADDR_W-2:0], sdIn};
    readNow = inSh[ADDR_W-1];
    sdOut   = strb.inSlot & outSh[WORD_W-1];
    regAddr = strb.ctrlMid ? addrNow : addrHold;
    regRead = strb.ctrlMid & readNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSh    <= '0;
      inSh     <= '0;
      addrHold <= '0;
      readHold <= 1'b0;
      dacWord  <= '0;
      dacValid <= 1'b0;
      regWData <= '0;
      regWrite <= 1'b0;
    end else begin
      dacValid <= 1'b0;
      regWrite <= 1'b0;
      if (strb.tick) begin
        if (strb.inSlot) inSh <= {inSh[WORD_W-2:0], sdIn};
        if (strb.loadAdc)                 outSh <= adcWord;
        else if (strb.clearOut)           outSh <= '0;
        else if (strb.ctrlMid && readNow) outSh <= {regRData, REG_W'(0)};
        else if (strb.inSlot)             outSh <= {outSh[WORD_W-2:0], 1'b0};
        if (strb.ctrlMid) begin
          addrHold <= addrNow;
          readHold <= readNow;
        end
        if (strb.dataEnd) begin
          dacWord  <= {inSh[WORD_W-2:0], sdIn};
          dacValid <= 1'b1;
        end
        if (strb.ctrlEnd && !readHold) begin
          regWData <= {inSh[REG_W-2:0], sdIn};
          regWrite <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port
  import fsp_pkg::*;
#(
  parameter int FRAME_BITS = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              fsEarly,
  input  logic              sckContinuous,
  input  logic              ctrlQuarter,
  input  logic              fsdEnable,
  input  logic              sclkIn,
  input  logic              fsIn,
  input  logic              sdIn,
  input  logic [WORD_W-1:0] adcWord,
  input  logic [REG_W-1:0]  regRData,
  output logic              sclkGate,
  output logic              fsOut,
  output logic              fsdOut,
  output logic              sdOut,
  output logic [WORD_W-1:0] dacWord,
  output logic              dacValid,
  output logic [ADDR_W-1:0] regAddr,
  output logic [REG_W-1:0]  regWData,
  output logic              regRead,
  output logic              regWrite
);
  fsp_strobe_t strb;

  fsp_sequencer #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .fsEarly(fsEarly),
    .sckContinuous(sckContinuous), .ctrlQuarter(ctrlQuarter),
    .fsdEnable(fsdEnable), .sclkIn(sclkIn), .fsIn(fsIn),
    .fsOut(fsOut), .fsdOut(fsdOut), .sclkGate(sclkGate), .strb(strb)
  );

  fsp_shifter u_shift (
    .clk(clk), .rstN(rstN), .strb(strb), .sdIn(sdIn), .adcWord(adcWord),
    .regRData(regRData), .sdOut(sdOut), .dacWord(dacWord), .dacValid(dacValid),
    .regAddr(regAddr), .regWData(regWData), .regRead(regRead), .regWrite(regWrite)
  );
endmodule

// File: rtl/framed_serial_port_chk.sv
module framed_serial_port_chk (
  input logic clk,
  input logic rstN,
  input logic slaveMode,
  input logic sckContinuous,
  input logic fsOut,
  input logic fsdOut,
  input logic sclkGate,
  input logic dacValid,
  input logic regRead,
  input logic regWrite
);
  logic [7:0] sinceFs;
  logic       seenFs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceFs <= '0;
      seenFs  <= 1'b0;
    end else if (fsOut) begin
      sinceFs <= 8'd1;
      seenFs  <= 1'b1;
    end else if (sinceFs != 8'hFF) begin
      sinceFs <= sinceFs + 8'd1;
    end
  end

  assert_fs_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && fsOut) |=> !fsOut);

  assert_gate_at_fs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && !sckContinuous && fsOut) |-> sclkGate);

  assert_fsd_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && seenFs && fsdOut) |-> (sinceFs == 8'd16));

  assert_dac_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |=> !dacValid);

  assert_write_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> !regWrite);

  assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(regRead && regWrite));
endmodule

bind framed_serial_port framed_serial_port_chk u_chk (.*);

// File: tb/framed_serial_port_tb.sv
module framed_serial_port_tb;
  localparam int N = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, slaveMode = 1'b0, fsEarly = 1'b0, sckContinuous = 1'b0;
  logic ctrlQuarter = 1'b0, fsdEnable = 1'b0, sclkIn = 1'b0, fsIn = 1'b0, sdIn = 1'b0;
  logic [15:0] adcWord = '0;
  logic [7:0]  regRData;
  logic sclkGate, fsOut, fsdOut, sdOut, dacValid, regRead, regWrite;
  logic [15:0] dacWord;
  logic [6:0]  regAddr;
  logic [7:0]  regWData;

  assign regRData = {1'b0, regAddr} ^ 8'hA5;

  framed_serial_port #(.FRAME_BITS(N)) u_dut (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .fsEarly(fsEarly),
    .sckContinuous(sckContinuous), .ctrlQuarter(ctrlQuarter), .fsdEnable(fsdEnable),
    .sclkIn(sclkIn), .fsIn(fsIn), .sdIn(sdIn), .adcWord(adcWord), .regRData(regRData),
    .sclkGate(sclkGate), .fsOut(fsOut), .fsdOut(fsdOut), .sdOut(sdOut),
    .dacWord(dacWord), .dacValid(dacValid), .regAddr(regAddr), .regWData(regWData),
    .regRead(regRead), .regWrite(regWrite)
  );

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  logic [15:0] sdoQ[$];
  logic [15:0] dacQ[$];
  logic [14:0] wrQ[$];

  // per-frame driver state
  logic [15:0] hostWord, ctrlWord, sdoAcc;
  logic [6:0]  curAddr;
  logic        curRead;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic popCheck16(input string req, ref logic [15:0] q[$], input logic [15:0] act);
    if (q.size() == 0) chk(req, 32'hDEAD, 32'h0);
    else chk(req, act, q.pop_front());
  endtask

  task automatic applyReset(input logic slv, input logic early, input logic cont,
                            input logic quarter, input logic fsdEn);
    rstN = 1'b0; sclkIn = 1'b0; fsIn = 1'b0; sdIn = 1'b0;
    slaveMode = slv; fsEarly = early; sckContinuous = cont;
    ctrlQuarter = quarter; fsdEnable = fsdEn;
    repeat (2) @(negedge clk);
    #1;
    chk("R10", {sdOut, dacValid, regRead, regWrite}, 4'b0);
    chk("R10", dacWord, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor: compares one master-mode cycle against the requirements
  task automatic monitorCycle(input int m, input int cp, input logic early,
                              input logic cont, input logic fsdEn);
    int fsD, fsC, dd, dc;
    logic expFs, ctrlSide;
    fsD = early ? N - 1 : 0;
    fsC = early ? cp - 1 : cp;
    dd = (m - fsD + N) % N;
    dc = (m - fsC + N) % N;
    expFs = (dd == 0) || (dc == 0);
    ctrlSide = (m == cp) || (m == cp - 1);
    if (ctrlSide) chk("R2", fsOut, expFs);
    else          chk("R1", fsOut, expFs);
    chk("R3", sclkGate, cont || dd < 32 || dc < 32);
    chk("R4", fsdOut, fsdEn && (dd == 16 || dc == 16));
    if (m < 16 || (m >= cp && m < cp + 16)) begin
      sdoAcc = {sdoAcc[14:0], sdOut};
      if (m == 15)      popCheck16("R5", sdoQ, sdoAcc);
      if (m == cp + 15) popCheck16("R6", sdoQ, sdoAcc);
    end else begin
      chk("R8", sdOut, 1'b0);
    end
    chk("R5", dacValid, m == 16);
    if (dacValid) popCheck16("R5", dacQ, dacWord);
    chk("R6", regRead, curRead && m == cp + 7);
    if (regRead) chk("R6", regAddr, curAddr);
    chk("R7", regWrite, !curRead && m == cp + 16);
    if (regWrite) begin
      if (wrQ.size() == 0) chk("R7", 32'hDEAD, 32'h0);
      else chk("R7", {regAddr, regWData}, wrQ.pop_front());
    end
  endtask

  task automatic runMaster(input logic early, input logic cont, input logic quarter,
                           input logic fsdEn, input int frames);
    int cp;
    logic [15:0] adcNext;
    logic [7:0]  wdat;
    cp = quarter ? N / 4 : N / 2;
    applyReset(1'b0, early, cont, quarter, fsdEn);
    adcNext = 16'h0;
    for (int n = 0; n < frames * N; n++) begin
      int m, f;
      m = n % N;
      f = n / N;
      if (m == 0) begin
        // driver: expected items for this frame
        sdoQ.push_back(adcNext);            // R10: frame 0 sends the reset value
        adcNext = 16'h9A3C ^ 16'(f * 16'h1357) ^ {15'h0, early};
        adcWord = adcNext;
        hostWord = 16'hB4E1 ^ 16'(f * 16'h0F1F) ^ {15'h0, cont};
        dacQ.push_back(hostWord);
        curRead = f[0];
        curAddr = 7'(f * 13 + 5 + (quarter ? 40 : 0));
        wdat = 8'(f * 29 + 3);
        ctrlWord = {curRead, curAddr, curRead ? 8'h00 : wdat};
        sdoQ.push_back(curRead ? {8'h00, ({1'b0, curAddr} ^ 8'hA5)} : 16'h0);
        if (!curRead) wrQ.push_back({curAddr, wdat});
      end
      if (m < 16)                      sdIn = hostWord[15 - m];
      else if (m >= cp && m < cp + 16) sdIn = ctrlWord[15 - (m - cp)];
      else                             sdIn = 1'b0;
      #1;
      monitorCycle(m, cp, early, cont, fsdEn);
      @(negedge clk);
    end
  endtask

  task automatic runSlave();
    logic [15:0] hw1, hw2, acc, w;
    int dacSeen;
    hw1 = 16'h5AF0; hw2 = 16'h0FF1; acc = '0; dacSeen = 0;
    applyReset(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    adcWord = 16'hC3A5;
    for (int c = 0; c < 2 * (5 + N + 40); c++) begin
      int k, rel;
      logic tk, inData;
      k = c / 2;
      tk = (c % 2 == 0);
      rel = (k >= 5) ? (k - 5) % N : -1;
      inData = tk && rel >= 0 && rel < 16;
      w = (k < 5 + N) ? hw1 : hw2;
      sclkIn = tk;
      fsIn = tk && (k == 5 || k == 5 + N);
      sdIn = inData ? w[15 - rel] : 1'b0;
      #1;
      chk("R9", {fsOut, sclkGate}, 2'b00);
      chk("R9", fsdOut, tk && (rel == 16 || rel == N / 2 + 16));
      if (inData) begin
        acc = {acc[14:0], sdOut};
        if (rel == 15) chk("R9", acc, (k < 5 + N) ? 16'h0 : 16'hC3A5);
      end
      if (dacValid) begin
        chk("R9", dacWord, (dacSeen == 0) ? hw1 : hw2);
        dacSeen++;
      end
      @(negedge clk);
    end
    chk("R9", dacSeen, 2);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    curRead = 1'b0; curAddr = '0; hostWord = '0; ctrlWord = '0; sdoAcc = '0;
    runMaster(1'b0, 1'b0, 1'b0, 1'b1, 3);   // late, gated, midpoint
    runMaster(1'b1, 1'b0, 1'b1, 1'b1, 3);   // early, gated, quarter
    runMaster(1'b0, 1'b1, 1'b1, 1'b0, 3);   // late, continuous, quarter
    runMaster(1'b1, 1'b1, 1'b0, 1'b0, 3);   // early, continuous, midpoint
    chk("R5", sdoQ.size() + dacQ.size(), 0);
    chk("R7", wrQ.size(), 0);
    runSlave();
    finishRun();
  end

  initial begin
    #1ms;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end
endmodule